// File: doc/BRIEF.md
# Multi-Chip Display Address Decoder

This block sits between a host CPU bus and the display RAM of one column-driver chip in a group of up to four. The four chips tile a 480×320 panel as a 2×2 grid, and each chip stores 240×160 pixels of 4 bits. The host sees a single flat map. The low address byte counts pixel pairs across the panel, with two pixels to each byte. The upper nine bits count panel lines. Two placement inputs tell the chip which quadrant it owns. The decoder accepts only the accesses that fall in that quadrant and turns them into a local RAM word address and a write mask.

A RAM word is 16 bits wide and holds four packed pixels. The pixel with the lowest address sits in the least significant nibble. The bus can be 16 bits or 8 bits wide. In 16-bit mode two byte lanes are qualified separately. In 8-bit mode one lane is picked by the address. A small window of even addresses at the top of the map holds a 16-entry gray-scale palette. Every chip accepts palette writes, whatever its placement, and codes above the largest valid level are clamped. All outputs are registered one clock after the bus inputs.

Top module: `disp_addr_decoder`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every output is zero.
- R2: The address splits into a column byte c (bits 7..0) and a panel line g (bits 16..8). The access belongs to the chip when c < 240 and g < 320, (c >= 120) equals tile_pos[0], and (g >= 160) equals tile_pos[1]. Any other address gives no hit.
- R3: An access needs sel_n low. It is a read when rd_n is low and wr_n is high, and a write when wr_n is low and rd_n is high. If both strobes are low or both are high, nothing happens. When there is no hit, acc_rd, ram_addr, ram_wmask and ram_wdata are zero. When pal_we is low, pal_idx and pal_code are zero.
- R4: On a hit, ram_addr equals (g mod 160) * 60 + (c mod 120) / 2.
- R5: In 16-bit mode (byte_bus low), address bit 0 low enables the low byte lane, which is mask bits 1..0. hi_byte_n low enables the high byte lane, which is mask bits 3..2. ram_wdata equals bus_data, and nibble 0 is the lowest-addressed pixel.
- R6: In 8-bit mode (byte_bus high), data arrives on bus_data[7:0]. Address bit 0 selects the low lane (0) or the high lane (1). ram_wdata carries that byte in both halves, and hi_byte_n has no effect.
- R7: A write that enables no byte lane gives no hit and no mask.
- R8: A write to an even address from 0x1FF80 to 0x1FF9E raises pal_we with pal_idx equal to address bits 4..1 and gives no RAM hit, for every tile_pos. Odd addresses and reads in that window do nothing.
- R9: The palette code is bus_data[5:0]. Values above 48 are written as 48.
- R10: Outputs reflect the bus inputs sampled on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 17 | Host address |
| bus_data | input | 16 | Host write data |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hi_byte_n | input | 1 | High byte lane enable, active low (16-bit mode) |
| byte_bus | input | 1 | High selects the 8-bit bus, low selects the 16-bit bus |
| tile_pos | input | 2 | Quadrant: bit 0 right half, bit 1 bottom half |
| acc_hit | output | 1 | RAM access for this chip |
| acc_rd | output | 1 | The hit is a read |
| ram_addr | output | 14 | Local RAM word address |
| ram_wmask | output | 4 | Per-nibble write enable |
| ram_wdata | output | 16 | RAM write data |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 4 | Palette entry |
| pal_code | output | 6 | Clamped gray code |

## Verification
The decoder keeps no state beyond one output register. Any decode error therefore shows at the ports one cycle after the faulty bus cycle: a missing or extra hit, a shifted word address, or a wrong lane in the mask. A behavioural model in the bench works out the panel pixel position and the owning quadrant arithmetically, and the outputs are compared with it on every clock. The tile edges at columns 119/120 and 239/240 and at lines 159/160 and 319/320 are driven directly, and so are the palette window edges.

// File: rtl/disp_addr_decoder.sv
module disp_addr_decoder #(
  parameter int TILE_COLS  = 240,
  parameter int TILE_LINES = 160,
  parameter int PAL_MAX    = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [16:0] bus_addr,
  input  logic [15:0] bus_data,
  input  logic        sel_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        hi_byte_n,
  input  logic        byte_bus,
  input  logic [1:0]  tile_pos,
  output logic        acc_hit,
  output logic        acc_rd,
  output logic [$clog2(TILE_COLS/4*TILE_LINES)-1:0] ram_addr,
  output logic [3:0]  ram_wmask,
  output logic [15:0] ram_wdata,
  output logic        pal_we,
  output logic [3:0]  pal_idx,
  output logic [5:0]  pal_code
);
  localparam int WPL   = TILE_COLS / 4;
  localparam int DEPTH = WPL * TILE_LINES;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [7:0] HALF_B  = 8'(TILE_COLS / 2);
  localparam logic [7:0] END_B   = 8'(TILE_COLS);
  localparam logic [8:0] HALF_L  = 9'(TILE_LINES);
  localparam logic [8:0] END_L   = 9'(2 * TILE_LINES);
  localparam logic [5:0] CODE_MX = 6'(PAL_MAX);

  logic [7:0] col_b;
  logic [8:0] line_g;
  logic       right, bottom, in_range, mine;
  logic [7:0] loc_c;
  logic [8:0] loc_l;
  logic [AW-1:0] word_a;
  logic       rd_acc, wr_acc, lane_lo, lane_hi, hit_d, pal_d;
  logic [5:0] code_d;

  assign col_b    = bus_addr[7:0];
  assign line_g   = bus_addr[16:8];
  assign right    = col_b >= HALF_B;
  assign bottom   = line_g >= HALF_L;
  assign in_range = (col_b < END_B) && (line_g < END_L);
  assign mine     = in_range && (right == tile_pos[0]) && (bottom == tile_pos[1]);
  assign loc_c    = right  ? col_b - HALF_B : col_b;
  assign loc_l    = bottom ? line_g - HALF_L : line_g;
  assign word_a   = AW'(loc_l) * AW'(WPL) + AW'(loc_c[7:1]);

  assign rd_acc  = ~sel_n & ~rd_n &  wr_n;
  assign wr_acc  = ~sel_n &  rd_n & ~wr_n;
  assign lane_lo = ~bus_addr[0];
  assign lane_hi = byte_bus ? bus_addr[0] : ~hi_byte_n;
  assign hit_d   = mine & (rd_acc | (wr_acc & (lane_lo | lane_hi)));

  assign pal_d  = wr_acc & (line_g == 9'h1FF) & (col_b[7:5] == 3'b100) & ~col_b[0];
  assign code_d = (bus_data[5:0] > CODE_MX) ? CODE_MX : bus_data[5:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_hit   <= 1'b0;
      acc_rd    <= 1'b0;
      ram_addr  <= '0;
      ram_wmask <= '0;
      ram_wdata <= '0;
      pal_we    <= 1'b0;
      pal_idx   <= '0;
      pal_code  <= '0;
    end else begin
      acc_hit   <= hit_d;
      acc_rd    <= hit_d & rd_acc;
      ram_addr  <= hit_d ? word_a : '0;
      ram_wmask <= (hit_d & wr_acc) ? {lane_hi, lane_hi, lane_lo, lane_lo} : 4'b0;
      ram_wdata <= (hit_d & wr_acc) ? (byte_bus ? {2{bus_data[7:0]}} : bus_data) : 16'h0;
      pal_we    <= pal_d;
      pal_idx   <= pal_d ? col_b[4:1] : 4'h0;
      pal_code  <= pal_d ? code_d : 6'h0;
    end
  end

  p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wmask != 4'b0) |-> (acc_hit && !acc_rd));
  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n) |-> (!acc_hit && !pal_we));
  p_code_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (pal_code <= CODE_MX));
  p_pal_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> !acc_hit);
  p_addr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (int'(ram_addr) < DEPTH));
  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byte_bus) && (ram_wmask != 4'b0)) |-> ($countones(ram_wmask) == 2));
endmodule

// File: tb/disp_addr_decoder_tb.sv
module disp_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hi_byte_n = 1'b1, byte_bus = 1'b0;
  logic [1:0]  tile_pos = 2'd0;
  logic        acc_hit, acc_rd, pal_we;
  logic [13:0] ram_addr;
  logic [3:0]  ram_wmask, pal_idx;
  logic [15:0] ram_wdata;
  logic [5:0]  pal_code;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic hit; logic rd; logic [13:0] addr; logic [3:0] mask; logic [15:0] wdata;
    logic pwe; logic [3:0] pidx; logic [5:0] pcode;
  } exp_t;

  always #10 clk = ~clk;

  disp_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .hi_byte_n(hi_byte_n),
    .byte_bus(byte_bus), .tile_pos(tile_pos), .acc_hit(acc_hit), .acc_rd(acc_rd),
    .ram_addr(ram_addr), .ram_wmask(ram_wmask), .ram_wdata(ram_wdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_code(pal_code));

  function automatic exp_t model(input logic [16:0] a, input logic [15:0] d,
      input logic s, input logic o, input logic w, input logic u,
      input logic bb, input logic [1:0] p);
    exp_t e = '0;
    int c = int'(a[7:0]);
    int g = int'(a[16:8]);
    int px = 2 * c;
    bit rd = !s && !o && w;
    bit wr = !s && o && !w;
    bit lo = !a[0];
    bit hi = bb ? a[0] : !u;
    bit mine = (c < 240) && (g < 320) && (px / 240 == int'(p[0])) && (g / 160 == int'(p[1]));
    if (mine && (rd || (wr && (lo || hi)))) begin
      e.hit = 1;
      e.rd = rd;
      e.addr = 14'((g % 160) * 60 + (px % 240) / 4);
      if (wr) begin
        e.mask = {hi, hi, lo, lo};
        e.wdata = bb ? {d[7:0], d[7:0]} : d;
      end
    end
    if (wr && g == 511 && c >= 128 && c <= 158 && c % 2 == 0) begin
      e.pwe = 1;
      e.pidx = 4'((c - 128) / 2);
      e.pcode = (d[5:0] > 6'd48) ? 6'd48 : d[5:0];
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t got = {acc_hit, acc_rd, ram_addr, ram_wmask, ram_wdata, pal_we, pal_idx, pal_code};
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s got hit=%0b rd=%0b addr=%0d mask=%h wdata=%h pwe=%0b pidx=%0d pcode=%0d exp hit=%0b rd=%0b addr=%0d mask=%h wdata=%h pwe=%0b pidx=%0d pcode=%0d",
        tag, got.hit, got.rd, got.addr, got.mask, got.wdata, got.pwe, got.pidx, got.pcode,
        e.hit, e.rd, e.addr, e.mask, e.wdata, e.pwe, e.pidx, e.pcode);
    end
  endtask

  // R10: inputs set after a falling edge, outputs checked at the next falling edge
  task automatic step(input logic [16:0] a, input logic [15:0] d, input logic s,
      input logic o, input logic w, input logic u, input logic bb,
      input logic [1:0] p, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a; bus_data = d; sel_n = s; rd_n = o; wr_n = w;
    hi_byte_n = u; byte_bus = bb; tile_pos = p;
    e = model(a, d, s, o, w, u, bb, p);
    @(negedge clk);
    compare(e, tag);
  endtask

  function automatic logic [16:0] ad(input int line, input int col);
    return {9'(line), 8'(col)};
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_addr = ad(5, 10); sel_n = 0; rd_n = 0;
    @(negedge clk);
    compare('0, "R1 during reset");
    @(negedge clk);
    rst_n = 1;
    sel_n = 1; rd_n = 1;
    @(negedge clk);
    compare('0, "R1 after reset");

    // R2 quadrant ownership and boundaries
    step(ad(5, 10), 16'h0, 0, 0, 1, 1, 0, 2'd0, "R2 read own tile");
    step(ad(5, 10), 16'h0, 0, 0, 1, 1, 0, 2'd1, "R2 other tile");
    step(ad(5, 119), 16'h0, 0, 0, 1, 1, 0, 2'd0, "R2 col 119 left");
    step(ad(5, 120), 16'h0, 0, 0, 1, 1, 0, 2'd1, "R2 col 120 right");
    step(ad(159, 3), 16'h0, 0, 0, 1, 1, 0, 2'd2, "R2 line 159 not bottom");
    step(ad(160, 3), 16'h0, 0, 0, 1, 1, 0, 2'd2, "R2 line 160 bottom");
    for (int p = 0; p < 4; p++) begin
      step(ad(10, 240), 16'h0, 0, 0, 1, 1, 0, 2'(p), "R2 col 240 none");
      step(ad(320, 4), 16'h0, 0, 0, 1, 1, 0, 2'(p), "R2 line 320 none");
    end
    // R3 strobes
    step(ad(5, 10), 16'h1234, 1, 1, 0, 0, 0, 2'd0, "R3 deselected write");
    step(ad(5, 10), 16'h1234, 0, 0, 0, 0, 0, 2'd0, "R3 both strobes");
    step(ad(5, 10), 16'h1234, 0, 1, 1, 0, 0, 2'd0, "R3 no strobe");
    // R4 address corners
    step(ad(319, 239), 16'h0, 0, 0, 1, 1, 0, 2'd3, "R4 last word");
    step(ad(200, 131), 16'hBEEF, 0, 1, 0, 0, 1, 2'd3, "R4 mid word");
    // R5 16-bit lanes
    step(ad(7, 20), 16'hA5C3, 0, 1, 0, 0, 0, 2'd0, "R5 both lanes");
    step(ad(7, 20), 16'hA5C3, 0, 1, 0, 1, 0, 2'd0, "R5 low lane");
    step(ad(7, 21), 16'hA5C3, 0, 1, 0, 0, 0, 2'd0, "R5 high lane");
    // R6 8-bit lanes
    step(ad(7, 21), 16'h9F3C, 0, 1, 0, 1, 1, 2'd0, "R6 byte odd");
    step(ad(7, 22), 16'h9F3C, 0, 1, 0, 0, 1, 2'd0, "R6 byte even ube ignored");
    // R7 no lanes
    step(ad(7, 21), 16'h1111, 0, 1, 0, 1, 0, 2'd0, "R7 no lane write");
    // R8 palette
    step(17'h1FF84, 16'h0015, 0, 1, 0, 1, 0, 2'd0, "R8 palette idx2");
    step(17'h1FF9E, 16'h0007, 0, 1, 0, 1, 1, 2'd3, "R8 palette idx15");
    step(17'h1FF80, 16'h0001, 0, 1, 0, 1, 0, 2'd2, "R8 palette idx0");
    step(17'h1FF85, 16'h0015, 0, 1, 0, 1, 0, 2'd0, "R8 odd palette");
    step(17'h1FFA0, 16'h0015, 0, 1, 0, 1, 0, 2'd0, "R8 past window");
    step(17'h1FF84, 16'h0015, 0, 0, 1, 1, 0, 2'd0, "R8 palette read");
    // R9 clamp
    step(17'h1FF86, 16'h003F, 0, 1, 0, 1, 0, 2'd0, "R9 clamp 63");
    step(17'h1FF88, 16'h0031, 0, 1, 0, 1, 0, 2'd0, "R9 clamp 49");
    step(17'h1FF8A, 16'h0030, 0, 1, 0, 1, 0, 2'd0, "R9 keep 48");

    // R4 randomized sweep over tiles, lanes and strobes
    for (int i = 0; i < 4000; i++) begin
      logic [16:0] a;
      int sel = $urandom_range(0, 9);
      if (sel == 0) a = {9'h1FF, 8'($urandom_range(120, 170))};
      else a = ad($urandom_range(0, 340), $urandom_range(0, 255));
      step(a, 16'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom), "R4 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule